// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a fully associative cache of address translations. Each of its entries binds a virtual page number and a context (process) identifier to a physical frame number. A lookup presents a page number and a context. One cycle later the block reports either a hit with the frame number or a miss trap. A miss only means that the translation is not cached. It says nothing about whether the page is resident in memory, and the block never walks page tables itself.

After a miss, software resolves the translation and installs it through the fill port. A fill goes to the entry that already holds the same page/context pair if there is one. Otherwise it goes to the lowest-numbered empty entry. When the buffer is full, it replaces the least recently used entry. Both lookup hits and fills count as uses. Software can also drop every entry of one context, or empty the whole buffer at once. A core would normally use one instance for instruction fetches and another for data accesses.

Top module: `ctx_tlb`

## Requirements
- R1: A lookup hits only when a valid entry matches both the page number and the context. One cycle after `req_valid`, `rsp_hit`=1, `rsp_miss_trap`=0 and `rsp_pfn` carries that entry's frame number.
- R2: A lookup that matches no valid entry gives `rsp_miss_trap`=1, `rsp_hit`=0 and `rsp_pfn`=0 one cycle later, and leaves the stored translations unchanged.
- R3: In a cycle that follows a cycle without `req_valid`, `rsp_hit` and `rsp_miss_trap` are both 0.
- R4: A fill whose page/context pair is already held by a valid entry overwrites that entry's frame number and creates no second copy.
- R5: A fill of a new pair writes the lowest-numbered invalid entry, and that pair then hits.
- R6: When every entry is valid, a fill of a new pair replaces the least recently used entry. A lookup hit and a fill each make their entry the most recently used.
- R7: When a lookup hit and a fill fall in the same cycle, the hit's recency update is applied first. The replacement victim is chosen after it, so the entry that just hit is never the one evicted.
- R8: `inval_ctx_en` invalidates every entry whose context equals `inval_ctx` and leaves entries of other contexts in place.
- R9: `flush_all` invalidates every entry.
- R10: A fill in the same cycle as `flush_all` or `inval_ctx_en` is dropped. A lookup in that cycle reports the contents as they were before the clear.
- R11: After reset, every entry is invalid, and `rsp_hit` and `rsp_miss_trap` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | VPN_W | Lookup virtual page number |
| req_ctx | input | CTX_W | Lookup context identifier |
| rsp_hit | output | 1 | Translation found (one cycle after request) |
| rsp_pfn | output | PFN_W | Frame number on hit, zero otherwise |
| rsp_miss_trap | output | 1 | Translation absent; software must install it |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_ctx | input | CTX_W | Context to install |
| fill_pfn | input | PFN_W | Frame number to install |
| inval_ctx_en | input | 1 | Invalidate all entries of one context |
| inval_ctx | input | CTX_W | Context to invalidate |
| flush_all | input | 1 | Invalidate all entries |

## Verification
A lookup and a fill can land in the same cycle. The hardest case is a lookup that hits the current least recently used entry while a fill of a new pair arrives on a full buffer. The bench provokes this by filling all 64 entries and then scanning them so that a known entry becomes the oldest. It then issues a lookup of that entry together with a fill. It judges the result by later lookups: the entry that just hit must survive, and the next-oldest entry must be the one that disappeared. A reference model decides which entry that is, using an ordered recency list rather than age counters. Fills that coincide with a flush or a context invalidate are checked the same way.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int DEF_ENTRIES = 64;
  localparam int DEF_VPN_W   = 31;
  localparam int DEF_PFN_W   = 28;
  localparam int DEF_CTX_W   = 13;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
  parameter int VPN_W = 31,
  parameter int PFN_W = 28,
  parameter int CTX_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [CTX_W-1:0] lk_ctx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_en,
  input  logic             clr_all,
  input  logic             clr_ctx_en,
  input  logic [CTX_W-1:0] clr_ctx,
  output logic             valid,
  output logic             lk_match,
  output logic             wr_match,
  output logic [PFN_W-1:0] pfn
);
  logic [VPN_W-1:0] vpn_q;
  logic [CTX_W-1:0] ctx_q;
  logic             clr_hit;

  assign lk_match = valid && (vpn_q == lk_vpn) && (ctx_q == lk_ctx);
  assign wr_match = valid && (vpn_q == wr_vpn) && (ctx_q == wr_ctx);
  assign clr_hit  = clr_all || (clr_ctx_en && (ctx_q == clr_ctx));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      vpn_q <= '0;
      ctx_q <= '0;
      pfn   <= '0;
    end else if (clr_hit) begin
      valid <= 1'b0;
    end else if (wr_en) begin
      valid <= 1'b1;
      vpn_q <= wr_vpn;
      ctx_q <= wr_ctx;
      pfn   <= wr_pfn;
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_en,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  output logic [IDX_W-1:0]   lru_idx,
  output logic [ENTRIES-1:0] lru_vec
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age_q   [ENTRIES];
  logic [IDX_W-1:0] age_mid [ENTRIES];
  logic [IDX_W-1:0] age_nxt [ENTRIES];

  // Age after one entry is made youngest: that entry goes to 0,
  // entries younger than it grow one step older.
  function automatic logic [IDX_W-1:0] aged(input logic [IDX_W-1:0] own,
                                            input logic [IDX_W-1:0] tgt,
                                            input logic             is_tgt);
    if (is_tgt)         return '0;
    else if (own < tgt) return own + 1'b1;
    else                return own;
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      age_mid[i] = hit_en ? aged(age_q[i], age_q[hit_idx], IDX_W'(i) == hit_idx)
                          : age_q[i];
  end

  always_comb begin
    lru_idx = '0;
    lru_vec = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (age_mid[i] == OLDEST) begin
        lru_idx    = IDX_W'(i);
        lru_vec[i] = 1'b1;
      end
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      age_nxt[i] = fill_en ? aged(age_mid[i], age_mid[fill_idx], IDX_W'(i) == fill_idx)
                           : age_mid[i];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      age_q[i] <= rst_n ? age_nxt[i] : IDX_W'(i);
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = DEF_ENTRIES,
  parameter int VPN_W   = DEF_VPN_W,
  parameter int PFN_W   = DEF_PFN_W,
  parameter int CTX_W   = DEF_CTX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [CTX_W-1:0] req_ctx,
  output logic             rsp_hit,
  output logic [PFN_W-1:0] rsp_pfn,
  output logic             rsp_miss_trap,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [CTX_W-1:0] fill_ctx,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             inval_ctx_en,
  input  logic [CTX_W-1:0] inval_ctx,
  input  logic             flush_all
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_vec, lk_vec, wr_match_vec, wr_vec, lru_vec;
  logic [PFN_W-1:0]   slot_pfn [ENTRIES];

  logic             lk_hit, fill_go, wr_match_any, free_any;
  logic [IDX_W-1:0] hit_idx, match_idx, free_idx, lru_idx, fill_idx;
  logic [PFN_W-1:0] lk_pfn;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_slot #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (req_vpn),
      .lk_ctx    (req_ctx),
      .wr_vpn    (fill_vpn),
      .wr_ctx    (fill_ctx),
      .wr_pfn    (fill_pfn),
      .wr_en     (wr_vec[g]),
      .clr_all   (flush_all),
      .clr_ctx_en(inval_ctx_en),
      .clr_ctx   (inval_ctx),
      .valid     (valid_vec[g]),
      .lk_match  (lk_vec[g]),
      .wr_match  (wr_match_vec[g]),
      .pfn       (slot_pfn[g])
    );
  end

  // A fill is dropped when a clear is requested in the same cycle.
  assign fill_go      = fill_en && !flush_all && !inval_ctx_en;
  assign lk_hit       = |lk_vec;
  assign wr_match_any = |wr_match_vec;
  assign free_any     = ~&valid_vec;

  // At most one entry matches a pair, so an AND-OR mux suffices.
  always_comb begin
    lk_pfn    = '0;
    hit_idx   = '0;
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      lk_pfn |= slot_pfn[i] & {PFN_W{lk_vec[i]}};
      if (lk_vec[i])       hit_idx   = IDX_W'(i);
      if (wr_match_vec[i]) match_idx = IDX_W'(i);
    end
  end

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_vec[i]) free_idx = IDX_W'(i);
  end

  always_comb begin
    if (wr_match_any)  fill_idx = match_idx;
    else if (free_any) fill_idx = free_idx;
    else               fill_idx = lru_idx;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++)
      wr_vec[i] = fill_go && (fill_idx == IDX_W'(i));
  end

  tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_en  (req_valid && lk_hit),
    .hit_idx (hit_idx),
    .fill_en (fill_go),
    .fill_idx(fill_idx),
    .lru_idx (lru_idx),
    .lru_vec (lru_vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit       <= 1'b0;
      rsp_miss_trap <= 1'b0;
      rsp_pfn       <= '0;
    end else begin
      rsp_hit       <= req_valid && lk_hit;
      rsp_miss_trap <= req_valid && !lk_hit;
      rsp_pfn       <= (req_valid && lk_hit) ? lk_pfn : '0;
    end
  end
endmodule

// File: rtl/ctx_tlb_chk.sv
module ctx_tlb_chk #(
  parameter int ENTRIES = 64,
  parameter int PFN_W   = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               rsp_hit,
  input logic               rsp_miss_trap,
  input logic [PFN_W-1:0]   rsp_pfn,
  input logic               fill_en,
  input logic               inval_ctx_en,
  input logic               flush_all,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] lru_vec
);
  p_resp_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit ^ rsp_miss_trap));

  p_miss_zero_pfn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss_trap |-> (rsp_pfn == '0));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_hit && !rsp_miss_trap));

  p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all && !inval_ctx_en) |=> (valid_vec != '0));

  p_single_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lru_vec) == 1);

  p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  p_flush_drops_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && fill_en) |=> (valid_vec == '0));
endmodule

bind ctx_tlb ctx_tlb_chk #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .rsp_hit      (rsp_hit),
  .rsp_miss_trap(rsp_miss_trap),
  .rsp_pfn      (rsp_pfn),
  .fill_en      (fill_en),
  .inval_ctx_en (inval_ctx_en),
  .flush_all    (flush_all),
  .valid_vec    (valid_vec),
  .lru_vec      (lru_vec)
);

// File: tb/ctx_tlb_bench.sv
`timescale 1ns/1ps
module ctx_tlb_bench;
  localparam int N  = 64;
  localparam int VW = 31;
  localparam int PW = 28;
  localparam int CW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, fill_en = 1'b0, inval_ctx_en = 1'b0, flush_all = 1'b0;
  logic [VW-1:0] req_vpn = '0, fill_vpn = '0;
  logic [CW-1:0] req_ctx = '0, fill_ctx = '0, inval_ctx = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic          rsp_hit, rsp_miss_trap;
  logic [PW-1:0] rsp_pfn;

  always #2.5 clk = ~clk;

  ctx_tlb u_ctx_tlb (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_ctx(req_ctx),
    .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_miss_trap(rsp_miss_trap),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ctx(fill_ctx), .fill_pfn(fill_pfn),
    .inval_ctx_en(inval_ctx_en), .inval_ctx(inval_ctx), .flush_all(flush_all)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // Reference model: contents plus a recency list, position 0 = newest.
  bit            m_valid [N];
  logic [VW-1:0] m_vpn   [N];
  logic [CW-1:0] m_ctx   [N];
  logic [PW-1:0] m_pfn   [N];
  int            m_order [N];

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_vpn[i] = '0; m_ctx[i] = '0; m_pfn[i] = '0;
      m_order[i] = i;
    end
  endfunction

  function automatic void m_touch(input int e);
    int pos = 0;
    for (int i = 0; i < N; i++) if (m_order[i] == e) pos = i;
    for (int i = pos; i > 0; i--) m_order[i] = m_order[i-1];
    m_order[0] = e;
  endfunction

  task automatic check(input string tag, input logic eh, input logic em, input logic [PW-1:0] ep);
    n_checks++;
    if (rsp_hit !== eh || rsp_miss_trap !== em || rsp_pfn !== ep) begin
      n_fail++;
      $display("FAIL %s: hit/miss/pfn got %0b/%0b/%h expected %0b/%0b/%h",
               tag, rsp_hit, rsp_miss_trap, rsp_pfn, eh, em, ep);
    end
  endtask

  // One cycle: drive now (at a falling edge), apply model, sample at next falling edge.
  task automatic step(input bit rv, input logic [VW-1:0] rvpn, input logic [CW-1:0] rctx,
                      input bit fe, input logic [VW-1:0] fvpn, input logic [CW-1:0] fctx,
                      input logic [PW-1:0] fpfn, input bit ie, input logic [CW-1:0] ictx,
                      input bit fl, input string tag);
    bit eh = 0; int hidx = -1; logic [PW-1:0] ep = '0; int slot = -1;
    req_valid = rv; req_vpn = rvpn; req_ctx = rctx;
    fill_en = fe; fill_vpn = fvpn; fill_ctx = fctx; fill_pfn = fpfn;
    inval_ctx_en = ie; inval_ctx = ictx; flush_all = fl;
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == rvpn && m_ctx[i] == rctx) begin eh = 1; hidx = i; ep = m_pfn[i]; end
    if (rv && eh) m_touch(hidx);
    if (fl) begin
      for (int i = 0; i < N; i++) m_valid[i] = 0;
    end else if (ie) begin
      for (int i = 0; i < N; i++) if (m_ctx[i] == ictx) m_valid[i] = 0;
    end else if (fe) begin
      for (int i = 0; i < N; i++)
        if (m_valid[i] && m_vpn[i] == fvpn && m_ctx[i] == fctx) slot = i;
      if (slot < 0)
        for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) slot = i;
      if (slot < 0) slot = m_order[N-1];
      m_valid[slot] = 1; m_vpn[slot] = fvpn; m_ctx[slot] = fctx; m_pfn[slot] = fpfn;
      m_touch(slot);
    end
    @(negedge clk);
    if (rv) check(tag, eh, !eh, rv && eh ? ep : '0);
    else    check({tag, "/R3"}, 1'b0, 1'b0, '0);
    req_valid = 0; fill_en = 0; inval_ctx_en = 0; flush_all = 0;
  endtask

  task automatic look(input logic [VW-1:0] v, input logic [CW-1:0] c, input string tag);
    step(1, v, c, 0, '0, '0, '0, 0, '0, 0, tag);
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [CW-1:0] c, input logic [PW-1:0] p, input string tag);
    step(0, '0, '0, 1, v, c, p, 0, '0, 0, tag);
  endtask

  // Vector fields: op[21:20] (0 lookup, 1 fill, 2 ctx invalidate, 3 flush), vpn[19:12], ctx[11:8], pfn[7:0]
  localparam int NV = 15;
  localparam logic [21:0] VEC [NV] = '{
    {2'd1, 8'h10, 4'd2, 8'hA1},
    {2'd1, 8'h11, 4'd2, 8'hA2},
    {2'd1, 8'h10, 4'd3, 8'hB1},
    {2'd0, 8'h10, 4'd2, 8'h00},
    {2'd0, 8'h10, 4'd3, 8'h00},
    {2'd0, 8'h10, 4'd4, 8'h00},
    {2'd0, 8'h12, 4'd2, 8'h00},
    {2'd1, 8'h10, 4'd2, 8'hC5},
    {2'd0, 8'h10, 4'd2, 8'h00},
    {2'd2, 8'h00, 4'd2, 8'h00},
    {2'd0, 8'h10, 4'd2, 8'h00},
    {2'd0, 8'h11, 4'd2, 8'h00},
    {2'd0, 8'h10, 4'd3, 8'h00},
    {2'd3, 8'h00, 4'd0, 8'h00},
    {2'd0, 8'h10, 4'd3, 8'h00}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    check("R11 reset outputs", 1'b0, 1'b0, '0);
    rst_n = 1'b1;
    look(31'h10, 13'd2, "R11 empty after reset");

    // Table walk: R1 hits, R2 misses, R4 overwrite, R5 fills, R8 ctx invalidate, R9 flush
    for (int k = 0; k < NV; k++) begin
      logic [1:0] op = VEC[k][21:20];
      logic [VW-1:0] v = VW'(VEC[k][19:12]);
      logic [CW-1:0] c = CW'(VEC[k][11:8]);
      logic [PW-1:0] p = PW'(VEC[k][7:0]);
      case (op)
        2'd0: look(v, c, "R1/R2 table lookup");
        2'd1: fill(v, c, p, "R4/R5 table fill");
        2'd2: step(0, '0, '0, 0, '0, '0, '0, 1, c, 0, "R8 table invalidate");
        default: step(0, '0, '0, 0, '0, '0, '0, 0, '0, 1, "R9 table flush");
      endcase
    end

    // R5: fill all entries, then R1 hit each one
    for (int i = 0; i < N; i++) fill(VW'(100 + i), 13'd1, PW'(28'h1000 + i), "R5 fill all");
    for (int i = 0; i < N; i++) look(VW'(100 + i), 13'd1, "R1 full scan");
    look(31'd100, 13'd2, "R2 context mismatch");

    // R7: hit on oldest entry while a new pair is filled
    step(1, 31'd100, 13'd1, 1, 31'd500, 13'd1, 28'h5000, 0, '0, 0, "R7 hit with fill");
    look(31'd100, 13'd1, "R7 hit entry kept");
    look(31'd101, 13'd1, "R7 next oldest evicted");
    look(31'd500, 13'd1, "R7 new pair present");

    // R6: more replacements follow recency
    fill(31'd600, 13'd1, 28'h6000, "R6 replace oldest");
    fill(31'd601, 13'd1, 28'h6001, "R6 replace oldest");
    for (int i = 0; i < 6; i++) look(VW'(100 + i), 13'd1, "R6 after replacement");
    look(31'd600, 13'd1, "R6 new pair");
    look(31'd601, 13'd1, "R6 new pair");

    // R10: fill with flush or invalidate in the same cycle is dropped
    step(0, '0, '0, 1, 31'd700, 13'd9, 28'h7000, 1, 13'd1, 0, "R10 fill with invalidate");
    look(31'd700, 13'd9, "R10 dropped fill");
    look(31'd110, 13'd1, "R8 context cleared");
    fill(31'd800, 13'd5, 28'h8000, "R5 refill");
    step(1, 31'd800, 13'd5, 0, '0, '0, '0, 0, '0, 1, "R10 lookup in flush cycle");
    look(31'd800, 13'd5, "R9 after flush");
    step(0, '0, '0, 1, 31'd801, 13'd5, 28'h8001, 0, '0, 1, "R10 fill with flush");
    look(31'd801, 13'd5, "R10 dropped fill");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule